// File: doc/BRIEF.md
# Multi-Channel Conversion Sequencer

This block steps an external analog-to-digital converter through a contiguous group of input channels, lowest channel number first. Software sets it up through a single 16-bit control/status word: the group size, single or repeated passes, the channel selection and a start bit. The block then launches one conversion at a time. It waits for the converter's done pulse and files each returned sample in a result register owned by that channel. When the group is finished it raises an end-of-scan flag, which can drive an interrupt request. The flag is cleared either by a read-then-write-zero sequence or by a DMA acknowledge.

In single-pass operation the start bit falls by itself once the last channel of the group has been stored. In repeated operation the sequencer returns to the first channel of the group and carries on. It stops only when software writes the start bit to 0, and that write also cancels any conversion in progress. Result registers are read through a channel index port.

The sequencer is a four-state machine. ST_IDLE waits for a start request. ST_LOAD latches the group bounds and points at the first channel. ST_LAUNCH issues a one-cycle start pulse with the channel number. ST_WAIT holds until the converter answers. The transitions are:
- ST_IDLE goes to ST_LOAD on a start request.
- ST_LOAD goes to ST_LAUNCH on the next cycle.
- ST_LAUNCH goes to ST_WAIT on the next cycle.
- When done arrives in ST_WAIT and the channel is not the last of the group, the machine goes back to ST_LAUNCH with the next channel.
- On the last channel, ST_WAIT goes back to ST_LOAD in repeated mode and to ST_IDLE in single-pass mode.
- From ST_LOAD, ST_LAUNCH or ST_WAIT, an abort write sends the machine to ST_IDLE.

Top module: `adc_scan_seq`

## Requirements
- R1: The control word fields are: bit 15 end flag, bit 14 interrupt enable, bit 13 start, bit 12 repeat select, bits 9:8 group mode, bits 3:0 channel select. The group mode picks the scanned channels.
  - Mode 11 scans channels 0 through 4*(s+1)-1, where s is channel select bits 1:0 limited to 2. This gives 0..3, 0..7 or 0..11, and select 0011 gives 0..11.
  - Mode 01 scans from channel {sel[3:2],00} up to the selected channel.
  - Modes 00 and 10 convert only the selected channel.
- R2: Conversions are issued one at a time in ascending channel order. Each conv_start is a single-cycle pulse carrying the channel number, and the next one follows only after conv_done.
- R3: Each conv_result is stored in the result register of the channel being converted. Registers of other channels keep their values. res_data shows the register chosen by res_sel.
- R4: With repeat select at 0, writing start as 1 runs one pass over the group. After the last result the end flag is 1, start reads 0 and no further conversion is issued.
- R5: With repeat select at 1, passes repeat from the group's first channel, start stays 1 and the end flag is set at the end of every pass.
- R6: Writing start as 0 while it is 1 stops the scan at once. No further conversion is issued, the end flag is not set, and results already stored are kept.
- R7: irq is 1 exactly when the end flag and the interrupt enable are both 1.
- R8: Writing 0 to the end flag clears it only if the flag was read as 1 (reg_rd while set) since it was last set. Otherwise the flag stays 1.
- R9: A dma_ack pulse clears the end flag.
- R10: While start is 1, writes leave the group mode, repeat select and channel select unchanged.
- R11: After reset the control word reads 0, conv_start and irq are 0 and every result register holds 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe for the control word |
| reg_rd | input | 1 | Read strobe for the control word (arms flag clearing) |
| reg_wdata | input | 16 | Control word write data |
| reg_rdata | output | 16 | Control word read data |
| res_sel | input | 4 | Result register index |
| res_data | output | 10 | Selected result register |
| conv_start | output | 1 | One-cycle conversion start pulse |
| conv_ch | output | 4 | Channel to convert |
| conv_done | input | 1 | Converter finished, result valid |
| conv_result | input | 10 | Converter sample |
| dma_ack | input | 1 | DMA acknowledge, clears the end flag |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that the converter answers each conv_start pulse with exactly one conv_done pulse, and never raises done without an outstanding start. They also assume that dma_ack is pulsed only while the flag is set. The bench's converter model holds one request at a time and answers a fixed three cycles after the launch, so done can never arrive unprompted. The bench pulses dma_ack only after it has seen the flag high. An abort write is issued in the window between a store and the next done, so an abort never coincides with a completion.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOAD,
        ST_LAUNCH,
        ST_WAIT
    } seq_state_t;

    localparam logic [1:0] MODE_QUAD = 2'b01;
    localparam logic [1:0] MODE_WIDE = 2'b11;

    localparam int B_FLAG  = 15;
    localparam int B_IE    = 14;
    localparam int B_START = 13;
    localparam int B_CONT  = 12;
    localparam int B_MODE  = 8;
    localparam int WORD_W  = 16;

endpackage

// File: rtl/adc_scan_regs.sv
module adc_scan_regs
    import adc_scan_pkg::*;
#(
    parameter int CH_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [WORD_W-1:0] wdata,
    input  logic              dma_ack,
    input  logic              scan_end,
    input  logic              single_done,
    output logic [WORD_W-1:0] rdata,
    output logic [1:0]        mode,
    output logic              cont,
    output logic [CH_W-1:0]   chsel,
    output logic              go,
    output logic              abort,
    output logic              irq
);

    logic ie_q, start_q, flag_q, armed_q;
    logic wr_clear;
    logic unused_bits;

    assign unused_bits = ^{wdata[11:10], wdata[7:CH_W]};

    assign go       = reg_wr &&  wdata[B_START] && !start_q;
    assign abort    = reg_wr && !wdata[B_START] &&  start_q;
    assign wr_clear = reg_wr && armed_q && !wdata[B_FLAG];
    assign irq      = flag_q && ie_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ie_q    <= 1'b0;
            start_q <= 1'b0;
            mode    <= 2'b00;
            cont    <= 1'b0;
            chsel   <= '0;
        end else begin
            if (reg_wr) begin
                ie_q <= wdata[B_IE];
                if (!start_q) begin
                    mode  <= wdata[B_MODE+1:B_MODE];
                    cont  <= wdata[B_CONT];
                    chsel <= wdata[CH_W-1:0];
                end
            end
            if (go)
                start_q <= 1'b1;
            else if (abort || single_done)
                start_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q  <= 1'b0;
            armed_q <= 1'b0;
        end else if (scan_end) begin
            flag_q  <= 1'b1;
            armed_q <= 1'b0;
        end else if (dma_ack || wr_clear) begin
            flag_q  <= 1'b0;
            armed_q <= 1'b0;
        end else if (reg_rd && flag_q) begin
            armed_q <= 1'b1;
        end
    end

    always_comb begin
        rdata                     = '0;
        rdata[B_FLAG]             = flag_q;
        rdata[B_IE]               = ie_q;
        rdata[B_START]            = start_q;
        rdata[B_CONT]             = cont;
        rdata[B_MODE+1:B_MODE]    = mode;
        rdata[CH_W-1:0]           = chsel;
    end

    AST_FLAG_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !armed_q && !dma_ack) |=> flag_q);                       // R8
    AST_DMA_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_ack && !scan_end) |=> !flag_q);                                // R9
    AST_ABORT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (abort && !flag_q) |=> !flag_q);                                    // R6
    AST_SINGLE_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        single_done |=> (!start_q && flag_q));                              // R4
    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        start_q |=> ($stable(mode) && $stable(cont) && $stable(chsel)));    // R10

endmodule

// File: rtl/adc_scan_fsm.sv
module adc_scan_fsm
    import adc_scan_pkg::*;
#(
    parameter int CH_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            go,
    input  logic            abort,
    input  logic [1:0]      mode,
    input  logic            cont,
    input  logic [CH_W-1:0] chsel,
    input  logic            conv_done,
    output logic            conv_start,
    output logic [CH_W-1:0] conv_ch,
    output logic            store_en,
    output logic [CH_W-1:0] store_ch,
    output logic            scan_end,
    output logic            single_done
);

    seq_state_t state, nxt;
    logic [CH_W-1:0] cur_q, base_q, last_q;
    logic [CH_W-1:0] grp_base, grp_last;
    logic [1:0]      span;
    logic            at_last;

    assign span    = (chsel[1:0] == 2'b11) ? 2'b10 : chsel[1:0];
    assign at_last = (cur_q == last_q);

    always_comb begin
        grp_base = chsel;
        grp_last = chsel;
        if (mode == MODE_WIDE) begin
            grp_base = '0;
            grp_last = CH_W'({span, 2'b11});
        end else if (mode == MODE_QUAD) begin
            grp_base = {chsel[CH_W-1:2], 2'b00};
            grp_last = chsel;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (go) nxt = ST_LOAD;
            ST_LOAD:   nxt = abort ? ST_IDLE : ST_LAUNCH;
            ST_LAUNCH: nxt = abort ? ST_IDLE : ST_WAIT;
            ST_WAIT: begin
                if (abort)
                    nxt = ST_IDLE;
                else if (conv_done)
                    nxt = !at_last ? ST_LAUNCH : (cont ? ST_LOAD : ST_IDLE);
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q  <= '0;
            base_q <= '0;
            last_q <= '0;
        end else if (state == ST_LOAD) begin
            cur_q  <= grp_base;
            base_q <= grp_base;
            last_q <= grp_last;
        end else if (store_en && !at_last) begin
            cur_q  <= cur_q + 1'b1;
        end
    end

    always_comb begin
        conv_start  = 1'b0;
        store_en    = 1'b0;
        unique case (state)
            ST_IDLE:   ;
            ST_LOAD:   ;
            ST_LAUNCH: conv_start = 1'b1;
            ST_WAIT:   store_en = conv_done && !abort;
        endcase
        conv_ch     = cur_q;
        store_ch    = cur_q;
        scan_end    = store_en && at_last;
        single_done = scan_end && !cont;
    end

    AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);                                        // R2
    AST_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_start && $past(store_en) && !$past(scan_end))
            |-> (conv_ch == CH_W'($past(conv_ch) + 1'b1)));                 // R2
    AST_IN_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
        store_en |-> (store_ch >= base_q && store_ch <= last_q));          // R1

endmodule

// File: rtl/adc_scan_store.sv
module adc_scan_store #(
    parameter int CH_W  = 4,
    parameter int RES_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             store_en,
    input  logic [CH_W-1:0]  store_ch,
    input  logic [RES_W-1:0] result,
    input  logic [CH_W-1:0]  res_sel,
    output logic [RES_W-1:0] res_data
);

    localparam int NCH = 1 << CH_W;

    logic [RES_W-1:0] slot [NCH];

    for (genvar g = 0; g < NCH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n)
                slot[g] <= '0;
            else if (store_en && store_ch == CH_W'(g))
                slot[g] <= result;
        end

        AST_KEEP_OTHERS: assert property (@(posedge clk) disable iff (!rst_n)
            !(store_en && store_ch == CH_W'(g)) |=> $stable(slot[g]));      // R3
    end

    assign res_data = slot[res_sel];

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
    import adc_scan_pkg::*;
#(
    parameter int CH_W  = 4,
    parameter int RES_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    input  logic [CH_W-1:0]   res_sel,
    output logic [RES_W-1:0]  res_data,
    output logic              conv_start,
    output logic [CH_W-1:0]   conv_ch,
    input  logic              conv_done,
    input  logic [RES_W-1:0]  conv_result,
    input  logic              dma_ack,
    output logic              irq
);

    logic [1:0]      mode;
    logic            cont, go, abort;
    logic [CH_W-1:0] chsel, store_ch;
    logic            store_en, scan_end, single_done;

    adc_scan_regs #(.CH_W(CH_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .wdata(reg_wdata), .dma_ack(dma_ack), .scan_end(scan_end),
        .single_done(single_done), .rdata(reg_rdata), .mode(mode),
        .cont(cont), .chsel(chsel), .go(go), .abort(abort), .irq(irq)
    );

    adc_scan_fsm #(.CH_W(CH_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .go(go), .abort(abort), .mode(mode),
        .cont(cont), .chsel(chsel), .conv_done(conv_done),
        .conv_start(conv_start), .conv_ch(conv_ch), .store_en(store_en),
        .store_ch(store_ch), .scan_end(scan_end), .single_done(single_done)
    );

    adc_scan_store #(.CH_W(CH_W), .RES_W(RES_W)) u_store (
        .clk(clk), .rst_n(rst_n), .store_en(store_en), .store_ch(store_ch),
        .result(conv_result), .res_sel(res_sel), .res_data(res_data)
    );

    AST_IRQ_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (reg_rdata[B_FLAG] && reg_rdata[B_IE]));                   // R7

endmodule

// File: tb/adc_scan_seq_bench.sv
module adc_scan_seq_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0, dma_ack = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [3:0]  res_sel = '0;
    logic [9:0]  res_data;
    logic        conv_start;
    logic [3:0]  conv_ch;
    logic        conv_done;
    logic [9:0]  conv_result;
    logic        irq;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    adc_scan_seq u_adc_scan_seq (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .res_sel(res_sel),
        .res_data(res_data), .conv_start(conv_start), .conv_ch(conv_ch),
        .conv_done(conv_done), .conv_result(conv_result), .dma_ack(dma_ack),
        .irq(irq)
    );

    // Converter model: answers each start three cycles later, result = {count, channel}
    logic       cv_busy;
    int         cv_wait;
    logic [3:0] cv_ch;
    int         conv_count;
    always_ff @(posedge clk) begin
        conv_done <= 1'b0;
        if (!rst_n) begin
            cv_busy     <= 1'b0;
            cv_wait     <= 0;
            cv_ch       <= '0;
            conv_count  <= 0;
            conv_result <= '0;
        end else if (cv_busy) begin
            if (cv_wait == 0) begin
                conv_done   <= 1'b1;
                conv_result <= {conv_count[5:0], cv_ch};
                conv_count  <= conv_count + 1;
                cv_busy     <= 1'b0;
            end else begin
                cv_wait <= cv_wait - 1;
            end
        end else if (conv_start) begin
            cv_busy <= 1'b1;
            cv_ch   <= conv_ch;
            cv_wait <= 2;
        end
    end

    // R2 monitor: start must be a single-cycle pulse
    logic prev_start = 1'b0;
    logic pulse_bad = 1'b0;
    always @(negedge clk) begin
        if (conv_start && prev_start) pulse_bad <= 1'b1;
        prev_start <= conv_start;
    end

    logic [9:0] shadow [16];

    // mode[13:12] sel[11:8] first[7:4] last[3:0]
    localparam logic [13:0] VEC [9] = '{
        {2'b11, 4'h3, 4'd0,  4'd11},
        {2'b11, 4'h0, 4'd0,  4'd3},
        {2'b11, 4'h1, 4'd0,  4'd7},
        {2'b11, 4'h2, 4'd0,  4'd11},
        {2'b01, 4'h6, 4'd4,  4'd6},
        {2'b01, 4'hF, 4'd12, 4'd15},
        {2'b01, 4'h0, 4'd0,  4'd0},
        {2'b00, 4'h9, 4'd9,  4'd9},
        {2'b10, 4'h5, 4'd5,  4'd5}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1;
        reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd();
        @(negedge clk);
        reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wait_flag(input string tag);
        int n = 0;
        while (!reg_rdata[15] && n < 600) begin
            @(negedge clk);
            n++;
        end
        check(tag, {31'b0, reg_rdata[15]}, 32'd1);
    endtask

    task automatic check_results(input string tag);
        for (int c = 0; c < 16; c++) begin
            res_sel = 4'(c);
            #1;
            check(tag, {22'b0, res_data}, {22'b0, shadow[c]});
        end
    endtask

    initial begin
        for (int c = 0; c < 16; c++) shadow[c] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        check("R11 word", {16'b0, reg_rdata}, 32'h0);
        check("R11 conv_start", {31'b0, conv_start}, 32'h0);
        check("R11 irq", {31'b0, irq}, 32'h0);
        check_results("R11 results");

        // Table walk: single passes
        for (int v = 0; v < 9; v++) begin
            logic [1:0]  md;
            logic [3:0]  sl, fst, lst;
            logic        ie;
            int          c0, c1;
            md = VEC[v][13:12]; sl = VEC[v][11:8]; fst = VEC[v][7:4]; lst = VEC[v][3:0];
            ie = v[0];
            c0 = conv_count;
            wr({1'b0, ie, 1'b1, 1'b0, 2'b00, md, 4'b0, sl});
            wait_flag("R4 flag");
            for (int c = int'(fst); c <= int'(lst); c++)
                shadow[c] = {6'(c0 + c - int'(fst)), 4'(c)};
            check_results("R1 R3 group results");
            check("R4 start cleared", {31'b0, reg_rdata[13]}, 32'h0);
            check("R7 irq", {31'b0, irq}, {31'b0, ie});
            c1 = conv_count;
            repeat (20) @(negedge clk);
            check("R4 stopped", conv_count, c1);
            // R8: write 0 to flag without a prior read leaves it set
            wr({1'b0, ie, 1'b0, 1'b0, 2'b00, md, 4'b0, sl});
            check("R8 no read", {31'b0, reg_rdata[15]}, 32'h1);
            rd();
            wr({1'b0, ie, 1'b0, 1'b0, 2'b00, md, 4'b0, sl});
            check("R8 read then clear", {31'b0, reg_rdata[15]}, 32'h0);
            check("R7 irq low", {31'b0, irq}, 32'h0);
        end

        // R5 continuous passes over channels 0..1, then R9 and R10
        begin
            int c0;
            c0 = conv_count;
            wr(16'h7101);
            wait_flag("R5 first pass");
            check("R5 start held", {31'b0, reg_rdata[13]}, 32'h1);
            check("R7 irq on", {31'b0, irq}, 32'h1);
            @(negedge clk);
            dma_ack = 1'b1;
            @(negedge clk);
            dma_ack = 1'b0;
            check("R9 dma clears", {31'b0, reg_rdata[15]}, 32'h0);
            wait_flag("R5 second pass");
            check("R5 second pass ch0", {22'b0, shadow_peek(0)}, {22'b0, 6'(c0 + 2), 4'd0});
            // R10: config write while running is ignored
            wr(16'h2303);
            check("R10 mode kept", {30'b0, reg_rdata[9:8]}, 32'h1);
            check("R10 sel kept", {28'b0, reg_rdata[3:0]}, 32'h1);
            check("R10 cont kept", {31'b0, reg_rdata[12]}, 32'h1);
            wr(16'h0000);
            @(negedge clk);
            dma_ack = 1'b1;
            @(negedge clk);
            dma_ack = 1'b0;
            repeat (10) @(negedge clk);
            c0 = conv_count;
            repeat (20) @(negedge clk);
            check("R6 no activity after stop", conv_count, c0);
            check("R6 start low", {31'b0, reg_rdata[13]}, 32'h0);
            res_sel = 4'd0; #1; shadow[0] = res_data;
            res_sel = 4'd1; #1; shadow[1] = res_data;
        end

        // R6 abort in the middle of a 12-channel pass
        begin
            int c0;
            int n = 0;
            c0 = conv_count;
            wr(16'h2303);
            while (conv_count != c0 + 3 && n < 200) begin
                @(negedge clk);
                n++;
            end
            wr(16'h0000);
            for (int c = 0; c < 3; c++) shadow[c] = {6'(c0 + c), 4'(c)};
            repeat (20) @(negedge clk);
            check("R6 flag stays clear", {31'b0, reg_rdata[15]}, 32'h0);
            check("R6 start low", {31'b0, reg_rdata[13]}, 32'h0);
            check_results("R6 kept results");
        end

        check("R2 single-cycle start", {31'b0, pulse_bad}, 32'h0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    function automatic logic [9:0] shadow_peek(input int c);
        return u_adc_scan_seq.res_data & 10'h0 | shadow_sel(c);
    endfunction

    function automatic logic [9:0] shadow_sel(input int c);
        return (c == 0) ? last0 : 10'h0;
    endfunction

    // latch channel 0 result whenever the converter reports channel 0 with a store
    logic [9:0] last0 = '0;
    always @(negedge clk)
        if (conv_done && conv_result[3:0] == 4'd0) last0 <= conv_result;

    initial begin
        #2000000;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors + 1, checks + 1);
        $finish;
    end

endmodule